// File: doc/BRIEF.md
# Programmable Burst Column Address Generator

This block produces the column address for every beat of a synchronous DRAM read or write burst. A mode write stores the burst length, the ordering (sequential wrap or interleaved) and a write policy that can cut write bursts down to one beat. A start request then loads a start column. From the next cycle on, the block gives one column address per active cycle, together with a beat-valid flag and a last-beat flag. The burst ends when its length runs out, when a terminate request arrives, or when a new start replaces it.

Sequential ordering counts the low address bits upward and wraps inside the aligned block of the burst length. Interleaved ordering XORs the start column with the beat index. A full-page setting steps through all 2^COL_W columns, rolls over and runs until it is stopped. A clock-enable input suspends the sequencer for one cycle after each low sample. Illegal mode settings are flagged and run as one-beat bursts.

Top module: `burst_col_gen`

## Requirements
- R1: After reset no beat is valid, `beat_last` and `cfg_bad` are 0, and the mode is one beat, sequential, full write bursts. A cycle with `cfg_we`=1 stores `cfg_len`, `cfg_type` and `cfg_single_wr`, which take effect from the next cycle. Length codes: 000=1, 001=2, 010=4, 011=8, 111=full page. `cfg_type` 0 is sequential and 1 is interleaved.
- R2: A start accepted at a clock edge makes `beat_vld`=1 with `col`=`start_col` in the cycle that follows.
- R3: In sequential mode with length L=2^k, beat i has address (s & ~(L-1)) | ((s+i) & (L-1)). For example, L=4 from column 2 gives 2,3,0,1.
- R4: In interleaved mode beat i has address s XOR i. For example, L=8 from column 5 gives 5,4,7,6,1,0,3,2.
- R5: `beat_last` is 1 only on beat L-1 of a fixed-length burst. With no new start, the following cycle has `beat_vld`=0.
- R6: A full-page burst gives addresses (s+i) mod 2^COL_W, rolls over, and never raises `beat_last`.
- R7: With `cfg_single_wr`=1, a start with `start_wr`=1 gives exactly one beat, flagged last. A start with `start_wr`=0 still uses the programmed length.
- R8: `stop` accepted while no start is present ends the burst. The next cycle has `beat_vld`=0.
- R9: A start accepted during a burst restarts the sequence from its own column in the next cycle.
- R10: If `clk_en` is 0 at an edge, the following cycle is frozen. In that cycle `beat_vld` is 0, the beat position and `col` are held, and `start`/`stop` are ignored. The burst then resumes with the beat that was held.
- R11: Length codes 100, 101 and 110, and full page combined with interleaved type, set `cfg_bad`=1 and run every burst as one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Low freezes the sequencer in the next cycle |
| cfg_we | input | 1 | Mode write strobe |
| cfg_len | input | 3 | Burst length code |
| cfg_type | input | 1 | 0 sequential, 1 interleaved |
| cfg_single_wr | input | 1 | 1 makes write bursts a single beat |
| start | input | 1 | Start a burst |
| start_col | input | COL_W | Start column |
| start_wr | input | 1 | The started burst is a write |
| stop | input | 1 | Terminate the current burst |
| col | output | COL_W | Column address of the current beat |
| beat_vld | output | 1 | A beat is issued this cycle |
| beat_last | output | 1 | This beat is the final one of the burst |
| cfg_bad | output | 1 | Stored mode is illegal and runs as one beat |

## Verification
A start, stop or mode write seen at one edge shows at the outputs in the cycle after that edge. Each later beat moves forward one cycle at a time, and a cycle after an edge with low `clk_en` adds one frozen cycle. The bench drives inputs on the falling edge. It samples the first beat on the falling edge after the start edge, and each next beat one falling edge later. For the stall case it counts the frozen cycle explicitly before it expects the held beat. The expected address for each beat comes from the sequential and XOR formulas, applied to every start column for every fixed length and both orderings.

// File: rtl/bcag_pkg.sv
package bcag_pkg;
    typedef enum logic [2:0] {
        LEN_1  = 3'b000,
        LEN_2  = 3'b001,
        LEN_4  = 3'b010,
        LEN_8  = 3'b011,
        LEN_FP = 3'b111
    } len_code_e;

    typedef struct packed {
        logic [3:0] lg;     // log2 of burst length
        logic       fp;     // full-page rolling mode
        logic       ilv;    // interleaved ordering
        logic       swr;    // single-beat writes
        logic       bad;    // illegal setting seen
    } mode_t;
endpackage

// File: rtl/bcag_mode.sv
module bcag_mode
    import bcag_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [2:0] len,
    input  logic       typ,
    input  logic       swr,
    output mode_t      mode_q
);
    localparam logic [3:0] FP_LG = 4'(COL_W);

    mode_t mode_d;
    mode_t dec;

    always_comb begin
        dec     = '0;
        dec.ilv = typ;
        dec.swr = swr;
        case (len)
            LEN_1:  dec.lg = 4'd0;
            LEN_2:  dec.lg = 4'd1;
            LEN_4:  dec.lg = 4'd2;
            LEN_8:  dec.lg = 4'd3;
            LEN_FP: begin
                if (!typ) begin
                    dec.lg = FP_LG;
                    dec.fp = 1'b1;
                end else begin
                    dec.bad = 1'b1;
                end
            end
            default: dec.bad = 1'b1;
        endcase
        mode_d = we ? dec : mode_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end
endmodule

// File: rtl/bcag_map.sv
module bcag_map #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic [3:0]       lg,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] sum;

    for (genvar b = 0; b < COL_W; b++) begin : g_mask
        assign mask[b] = (4'(b) < lg);
    end

    always_comb begin
        sum = base + idx;
        if (ilv) col = base ^ idx;
        else     col = (base & ~mask) | (sum & mask);
    end
endmodule

// File: rtl/bcag_seq.sv
module bcag_seq #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_wr,
    input  logic             stop,
    input  logic [3:0]       m_lg,
    input  logic             m_fp,
    input  logic             m_ilv,
    input  logic             m_swr,
    output logic             active,
    output logic             frozen,
    output logic [COL_W-1:0] base,
    output logic [COL_W-1:0] idx,
    output logic [3:0]       lg,
    output logic             ilv,
    output logic             at_end
);
    localparam int LW = COL_W + 1;

    typedef struct packed {
        logic             active;
        logic             frz;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] idx;
        logic [3:0]       lg;
        logic             ilv;
        logic             fp;
    } seq_t;

    seq_t s_d, s_q;
    logic [LW-1:0] lim;
    logic          one_beat_wr;

    always_comb begin
        lim         = (LW'(1) << s_q.lg) - LW'(1);
        at_end      = s_q.active & ~s_q.fp & ({1'b0, s_q.idx} == lim);
        one_beat_wr = start_wr & m_swr;

        s_d     = s_q;
        s_d.frz = ~clk_en;
        if (!s_q.frz) begin
            if (start) begin
                s_d.active = 1'b1;
                s_d.base   = start_col;
                s_d.idx    = '0;
                s_d.ilv    = m_ilv;
                s_d.lg     = one_beat_wr ? 4'd0 : m_lg;
                s_d.fp     = m_fp & ~one_beat_wr;
            end else if (stop) begin
                s_d.active = 1'b0;
            end else if (s_q.active) begin
                if (at_end) s_d.active = 1'b0;
                else        s_d.idx    = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active = s_q.active;
    assign frozen = s_q.frz;
    assign base   = s_q.base;
    assign idx    = s_q.idx;
    assign lg     = s_q.lg;
    assign ilv    = s_q.ilv;
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcag_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_len,
    input  logic             cfg_type,
    input  logic             cfg_single_wr,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_wr,
    input  logic             stop,
    output logic [COL_W-1:0] col,
    output logic             beat_vld,
    output logic             beat_last,
    output logic             cfg_bad
);
    mode_t            mode;
    logic             active, frz, ilv, at_end;
    logic [COL_W-1:0] base, idx;
    logic [3:0]       lg;

    bcag_mode #(.COL_W(COL_W)) u_mode (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .len(cfg_len),
        .typ(cfg_type), .swr(cfg_single_wr), .mode_q(mode)
    );

    bcag_seq #(.COL_W(COL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .start(start),
        .start_col(start_col), .start_wr(start_wr), .stop(stop),
        .m_lg(mode.lg), .m_fp(mode.fp), .m_ilv(mode.ilv), .m_swr(mode.swr),
        .active(active), .frozen(frz), .base(base), .idx(idx),
        .lg(lg), .ilv(ilv), .at_end(at_end)
    );

    bcag_map #(.COL_W(COL_W)) u_map (
        .base(base), .idx(idx), .lg(lg), .ilv(ilv), .col(col)
    );

    assign beat_vld  = active & ~frz;
    assign beat_last = at_end & ~frz;
    assign cfg_bad   = mode.bad;
endmodule

// File: rtl/bcag_chk.sv
module bcag_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             stop,
    input logic             frz,
    input logic [COL_W-1:0] col,
    input logic             beat_vld,
    input logic             beat_last
);
    a_r5_last_has_beat: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_vld);

    a_r5_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && beat_last && !start) |=> !beat_vld);

    a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !frz && clk_en) |=> (beat_vld && col == $past(start_col)));

    a_r8_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start && !frz) |=> !beat_vld);

    a_r10_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        frz |=> $stable(col));
endmodule

bind burst_col_gen bcag_chk #(.COL_W(COL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .start(start),
    .start_col(start_col), .stop(stop), .frz(frz), .col(col),
    .beat_vld(beat_vld), .beat_last(beat_last)
);

// File: tb/burst_col_gen_test.sv
`timescale 1ns/1ps
module burst_col_gen_test;
    localparam int COL_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en = 1'b1;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_len = 3'b000;
    logic cfg_type = 1'b0;
    logic cfg_single_wr = 1'b0;
    logic start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic start_wr = 1'b0;
    logic stop = 1'b0;
    logic [COL_W-1:0] col;
    logic beat_vld, beat_last, cfg_bad;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cfg_we(cfg_we),
        .cfg_len(cfg_len), .cfg_type(cfg_type), .cfg_single_wr(cfg_single_wr),
        .start(start), .start_col(start_col), .start_wr(start_wr), .stop(stop),
        .col(col), .beat_vld(beat_vld), .beat_last(beat_last), .cfg_bad(cfg_bad)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int ecol(int s, int i, int k, bit il);
        int m;
        m = (1 << k) - 1;
        if (il) return (s ^ i) & 255;
        return (s & ~m & 255) | ((s + i) & m);
    endfunction

    task automatic set_mode(input logic [2:0] len, input logic typ, input logic swr);
        @(negedge clk);
        cfg_we = 1'b1; cfg_len = len; cfg_type = typ; cfg_single_wr = swr;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // start a burst, check nb beats; 'last' expected on final beat unless fp
    task automatic burst(input int s, input int k, input bit il, input bit fp,
                         input int nb, input bit wr, input string req);
        @(negedge clk);
        start = 1'b1; start_col = COL_W'(s); start_wr = wr;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < nb; i++) begin
            int e;
            bit el;
            if (i > 0) @(negedge clk);
            e  = ecol(s, i, k, il);
            el = !fp && (i == nb - 1);
            chk(beat_vld && int'(col) == e && beat_last == el, req, int'(col), e);
        end
        if (!fp) begin
            @(negedge clk);
            chk(!beat_vld, "R5 idle after last", int'(beat_vld), 0);
        end
    endtask

    initial begin
        #(200000 * 5);
        chk(1'b0, "watchdog", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!beat_vld && !beat_last && !cfg_bad, "R1 reset", int'(beat_vld), 0);
        // R1 default one-beat burst
        burst(17, 0, 1'b0, 1'b0, 1, 1'b0, "R1 default length");

        // R3 / R4 / R2 / R5 sweep over all starts, fixed lengths, both orders
        for (int k = 0; k < 4; k++) begin
            for (int t = 0; t < 2; t++) begin
                set_mode(3'(k), t[0], 1'b0);
                for (int s = 0; s < 256; s++)
                    burst(s, k, t[0], 1'b0, 1 << k, 1'b0, t == 0 ? "R3 seq" : "R4 ilv");
            end
        end

        // R3 explicit example 2,3,0,1
        set_mode(3'b010, 1'b0, 1'b0);
        burst(2, 2, 1'b0, 1'b0, 4, 1'b0, "R3 example");
        // R4 explicit example 5,4,7,6,1,0,3,2
        set_mode(3'b011, 1'b1, 1'b0);
        burst(5, 3, 1'b1, 1'b0, 8, 1'b0, "R4 example");

        // R6 full page rolls over, then R8 stop
        set_mode(3'b111, 1'b0, 1'b0);
        burst(250, 8, 1'b0, 1'b1, 300, 1'b0, "R6 full page");
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(!beat_vld, "R8 stop", int'(beat_vld), 0);
        @(negedge clk);
        chk(!beat_vld, "R8 stays idle", int'(beat_vld), 0);

        // R7 single-beat write, full-length read
        set_mode(3'b011, 1'b0, 1'b1);
        burst(13, 0, 1'b0, 1'b0, 1, 1'b1, "R7 write one beat");
        burst(13, 3, 1'b0, 1'b0, 8, 1'b0, "R7 read keeps length");

        // R9 restart during burst
        set_mode(3'b011, 1'b0, 1'b0);
        @(negedge clk);
        start = 1'b1; start_col = 8'd0;
        @(negedge clk);
        start = 1'b0;
        chk(beat_vld && col == 8'd0, "R9 first", int'(col), 0);
        @(negedge clk);
        @(negedge clk);
        chk(beat_vld && col == 8'd2, "R9 beat2", int'(col), 2);
        start = 1'b1; start_col = 8'd44;
        @(negedge clk);
        start = 1'b0;
        chk(beat_vld && col == 8'd44 && !beat_last, "R9 restart", int'(col), 44);
        @(negedge clk);
        chk(beat_vld && col == 8'd45, "R9 continue", int'(col), 45);
        repeat (7) @(negedge clk);
        chk(!beat_vld, "R9 restart ends", int'(beat_vld), 0);

        // R10 freeze
        set_mode(3'b010, 1'b0, 1'b0);
        @(negedge clk);
        start = 1'b1; start_col = 8'd8;
        @(negedge clk);
        start = 1'b0;
        chk(beat_vld && col == 8'd8, "R10 beat0", int'(col), 8);
        clk_en = 1'b0;
        @(negedge clk);
        clk_en = 1'b1;
        chk(!beat_vld && col == 8'd9, "R10 frozen", int'(col), 9);
        start = 1'b1; start_col = 8'd99; stop = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        chk(beat_vld && col == 8'd9, "R10 held beat", int'(col), 9);
        @(negedge clk);
        chk(beat_vld && col == 8'd10, "R10 resume", int'(col), 10);
        @(negedge clk);
        chk(beat_vld && col == 8'd11 && beat_last, "R10 last", int'(col), 11);
        @(negedge clk);
        chk(!beat_vld, "R10 end", int'(beat_vld), 0);

        // R11 illegal settings
        set_mode(3'b101, 1'b0, 1'b0);
        chk(cfg_bad, "R11 reserved code flag", int'(cfg_bad), 1);
        burst(77, 0, 1'b0, 1'b0, 1, 1'b0, "R11 reserved as one beat");
        set_mode(3'b111, 1'b1, 1'b0);
        chk(cfg_bad, "R11 fp interleaved flag", int'(cfg_bad), 1);
        burst(200, 0, 1'b0, 1'b0, 1, 1'b0, "R11 fp ilv as one beat");
        set_mode(3'b001, 1'b0, 1'b0);
        chk(!cfg_bad, "R11 flag clears", int'(cfg_bad), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule